// File: doc/BRIEF.md
# Tagged-Token Matching and Firing Engine

This block is a compact dynamic dataflow engine. Each token that enters it carries a 32-bit data value, a destination node number, an operand side (A or B) and a context index that names one instance of that node. A token waits in a small associative matching store until its partner arrives. The partner has the same node and context and the opposite side. When the pair is complete the instance fires and adds the two values.

The program built into the block is an iterative Fibonacci generator. Every fired instance with context i sends its sum to the host tagged with i. While i is below MAX_I-1, it also sends the sum back into the engine twice: as an A operand for context i+1 and as a B operand for context i+2. These regenerated tokens enter an internal FIFO that is served before external input. Any token whose context is MAX_I or more is taken in and thrown away. This removes the one token per run that could never find a partner.

The host starts a run with three tokens: ctx 2 side A = f1, ctx 2 side B = f0, and ctx 3 side B = f1. With f0 = f1 = 1 this yields the Fibonacci numbers. The host collects results on a valid/ready stream and watches a done flag.

Top module: `tagmatch_engine`

## Requirements
- R1: After reset, out_valid is 0, done is 1, and in_ready is 1.
- R2: An instance fires only when two tokens with equal node and equal context are present and their side bits differ (side A = 0, side B = 1). A lone token, or two tokens on the same side, produce no output.
- R3: A firing puts one host token on the output. Its out_data is the 32-bit wraparound sum of the two operands and its out_ctx is the context of the instance.
- R4: A firing with context i below MAX_I-1 recirculates its sum to the same node twice: as side A for context i+1 and as side B for context i+2. A firing at context MAX_I-1 recirculates nothing.
- R5: A token with context MAX_I or more is accepted, never stored and never fired. It leaves done and the output unchanged.
- R6: While the recirculation FIFO holds a token, in_ready is 0.
- R7: When all STORE_DEPTH entries of the matching store are occupied, a token with no partner is refused (in_ready = 0). A token whose partner is stored is still accepted and fires.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_ctx hold their values.
- R9: After the three seed tokens, the host receives contexts 2 to MAX_I-1 in increasing order. Context k carries f(k) = f(k-1) + f(k-2) mod 2^32.
- R10: done is 1 exactly when the FIFO is empty, the matching store is empty and no host token is pending. With no input offered, done stays 1 once it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | External token offered |
| in_ready | output | 1 | External token taken this cycle |
| in_data | input | DATA_W | Token value |
| in_node | input | NODE_W | Destination node |
| in_ctx | input | CTX_W | Context index |
| in_port | input | 1 | Operand side, 0 = A, 1 = B |
| out_valid | output | 1 | Host result pending |
| out_ready | input | 1 | Host takes the result |
| out_data | output | DATA_W | Sum of the fired instance |
| out_ctx | output | CTX_W | Context of the fired instance |
| done | output | 1 | Engine empty and idle |

## Verification
Assertions watch the per-cycle rules on every cycle. The output holds under backpressure. The store is never written when full and never consumed without a match. The FIFO never overflows or underflows. Host contexts stay below MAX_I, and an idle engine stays idle without input. Only the bench scenarios can show the arithmetic and ordering results: the Fibonacci values for several seed pairs, with and without output backpressure, the wraparound sum, and the rejection of unmatched tokens once the store is full. They also show that discarded and same-side tokens leave no trace.

// File: rtl/tagmatch_pkg.sv
// Shared definitions for the tagged-token engine.
// Assumes a single operand-side bit per token.
package tagmatch_pkg;
    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;
endpackage

// File: rtl/tagmatch_store.sv
// Associative waiting store: finds the partner of a query token (same node and
// context, opposite side), inserts into the lowest free entry, and consumes the
// matched entry. Assumes the caller issues at most one of insert/consume per cycle.
module tagmatch_store #(
    parameter int DEPTH  = 8,
    parameter int NODE_W = 3,
    parameter int CTX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NODE_W-1:0] q_node,
    input  logic [CTX_W-1:0]  q_ctx,
    input  logic              q_side,
    input  logic              ins_en,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              del_en,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    output logic              full,
    output logic              empty
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  vld;
    logic [NODE_W-1:0] e_node [DEPTH];
    logic [CTX_W-1:0]  e_ctx  [DEPTH];
    logic              e_side [DEPTH];
    logic [DATA_W-1:0] e_data [DEPTH];
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  free_idx;

    // Search for the lowest matching entry and the lowest free entry.
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        full     = 1'b1;
        empty    = 1'b1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld[i] && e_node[i] == q_node && e_ctx[i] == q_ctx && e_side[i] != q_side) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!vld[i]) begin
                full     = 1'b0;
                free_idx = IDX_W'(i);
            end else begin
                empty = 1'b0;
            end
        end
    end

    assign hit_data = e_data[hit_idx];

    // Track valid bits: set on insert, clear on consume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (ins_en) vld[free_idx] <= 1'b1;
            if (del_en) vld[hit_idx]  <= 1'b0;
        end
    end

    // Capture token fields into the entry being filled.
    always_ff @(posedge clk) begin
        if (ins_en) begin
            e_node[free_idx] <= q_node;
            e_ctx[free_idx]  <= q_ctx;
            e_side[free_idx] <= q_side;
            e_data[free_idx] <= ins_data;
        end
    end

    // R7
    ins_room_chk: assert property (@(posedge clk) disable iff (!rst_n) ins_en |-> !full);
    // R2
    del_match_chk: assert property (@(posedge clk) disable iff (!rst_n) del_en |-> hit);
endmodule

// File: rtl/tagmatch_fifo.sv
// Recirculation FIFO: accepts zero or two tokens per cycle and pops one.
// Assumes DEPTH is a power of two and the writer checks room before a double push.
module tagmatch_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 42
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push2,
    input  logic [W-1:0]              wd0,
    input  logic [W-1:0]              wd1,
    input  logic                      pop,
    output logic [W-1:0]              head,
    output logic                      empty,
    output logic [$clog2(DEPTH):0]    cnt
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign head  = mem[rd_ptr];
    assign empty = (cnt == '0);

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push2) wr_ptr <= wr_ptr + PTR_W'(2);
            if (pop)   rd_ptr <= rd_ptr + PTR_W'(1);
            cnt <= cnt + (push2 ? ($clog2(DEPTH)+1)'(2) : '0) - (pop ? ($clog2(DEPTH)+1)'(1) : '0);
        end
    end

    // Store both pushed tokens in consecutive slots.
    always_ff @(posedge clk) begin
        if (push2) begin
            mem[wr_ptr]              <= wd0;
            mem[wr_ptr + PTR_W'(1)]  <= wd1;
        end
    end

    // R4
    fifo_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push2 |-> cnt <= ($clog2(DEPTH)+1)'(DEPTH - 2));
    // R6
    fifo_under_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/tagmatch_engine.sv
// Tagged-token engine running an iterative Fibonacci node: pairs operands by
// node/context/side, adds them, reports to the host and regenerates successors.
// Assumes MAX_I < 2**CTX_W so that context i+2 never wraps.
module tagmatch_engine #(
    parameter int DATA_W      = 32,
    parameter int NODE_W      = 3,
    parameter int CTX_W       = 6,
    parameter int MAX_I       = 40,
    parameter int STORE_DEPTH = 8,
    parameter int FIFO_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [NODE_W-1:0] in_node,
    input  logic [CTX_W-1:0]  in_ctx,
    input  logic              in_port,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [CTX_W-1:0]  out_ctx,
    output logic              done
);
    import tagmatch_pkg::*;

    localparam int TOK_W = DATA_W + NODE_W + CTX_W + 1;
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;
    localparam logic [CTX_W-1:0] LAST_CTX = CTX_W'(MAX_I - 1);

    logic [TOK_W-1:0]  f_head, f_wd0, f_wd1;
    logic              f_empty, f_pop, f_push2;
    logic [CNT_W-1:0]  f_cnt;
    logic [DATA_W-1:0] t_data, sum, hit_data;
    logic [NODE_W-1:0] t_node;
    logic [CTX_W-1:0]  t_ctx;
    logic              t_side, t_valid;
    logic              hit, s_full, s_empty;
    logic              drop, out_free, can_fire, take, accept, fire;

    // Pick the recirculated token first, external input otherwise.
    always_comb begin
        if (!f_empty) begin
            {t_data, t_node, t_ctx, t_side} = f_head;
            t_valid = 1'b1;
        end else begin
            {t_data, t_node, t_ctx, t_side} = {in_data, in_node, in_ctx, in_port};
            t_valid = in_valid;
        end
    end

    // Decide whether the selected token can be taken and what it does.
    always_comb begin
        drop     = t_ctx > LAST_CTX;
        out_free = !out_valid || out_ready;
        can_fire = out_free && (f_cnt <= CNT_W'(FIFO_DEPTH - 2));
        take     = drop || (hit ? can_fire : !s_full);
        accept   = t_valid && take;
        fire     = accept && !drop && hit;
        sum      = hit_data + t_data;
        in_ready = f_empty && take;
        f_pop    = accept && !f_empty;
        f_push2  = fire && (t_ctx < LAST_CTX);
        f_wd0    = {sum, t_node, t_ctx + CTX_W'(1), SIDE_A};
        f_wd1    = {sum, t_node, t_ctx + CTX_W'(2), SIDE_B};
        done     = f_empty && s_empty && !out_valid;
    end

    tagmatch_store #(
        .DEPTH(STORE_DEPTH), .NODE_W(NODE_W), .CTX_W(CTX_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .q_node(t_node), .q_ctx(t_ctx), .q_side(t_side),
        .ins_en(accept && !drop && !hit), .ins_data(t_data),
        .del_en(fire),
        .hit(hit), .hit_data(hit_data), .full(s_full), .empty(s_empty)
    );

    tagmatch_fifo #(.DEPTH(FIFO_DEPTH), .W(TOK_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push2(f_push2), .wd0(f_wd0), .wd1(f_wd1),
        .pop(f_pop), .head(f_head), .empty(f_empty), .cnt(f_cnt)
    );

    // Host result register: load on firing, clear when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ctx   <= '0;
        end else if (fire) begin
            out_valid <= 1'b1;
            out_data  <= sum;
            out_ctx   <= t_ctx;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ctx));
    // R5
    out_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_ctx <= LAST_CTX);
    // R10
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !in_valid |=> done);
endmodule

// File: tb/tb_tagmatch_engine.sv
module tb_tagmatch_engine;
    localparam int DATA_W = 32;
    localparam int NODE_W = 3;
    localparam int CTX_W  = 6;
    localparam int MAX_I  = 40;
    localparam int SDEPTH = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic [NODE_W-1:0] in_node = '0;
    logic [CTX_W-1:0]  in_ctx = '0;
    logic              in_port = 1'b0;
    logic              out_valid;
    logic              out_ready;
    logic [DATA_W-1:0] out_data;
    logic [CTX_W-1:0]  out_ctx;
    logic              done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int bp_mode = 0;
    int rec_n = 0;
    logic [DATA_W-1:0] rec_data [256];
    logic [CTX_W-1:0]  rec_ctx  [256];
    logic              held = 1'b0;
    logic [DATA_W-1:0] held_data;
    logic [CTX_W-1:0]  held_ctx;

    tagmatch_engine #(
        .DATA_W(DATA_W), .NODE_W(NODE_W), .CTX_W(CTX_W), .MAX_I(MAX_I),
        .STORE_DEPTH(SDEPTH), .FIFO_DEPTH(4)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_node(in_node), .in_ctx(in_ctx), .in_port(in_port),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_ctx(out_ctx), .done(done)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive out_ready, record transfers and check hold under backpressure.
    always @(negedge clk) begin
        logic rdy;
        cyc++;
        rdy = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        out_ready = rdy;
        if (held) begin
            // R8 held result must persist
            check(out_valid && out_data == held_data && out_ctx == held_ctx, "R8",
                  longint'(out_data), longint'(held_data));
        end
        held = out_valid && !rdy;
        held_data = out_data;
        held_ctx = out_ctx;
        if (out_valid && rdy && rec_n < 256) begin
            rec_data[rec_n] = out_data;
            rec_ctx[rec_n] = out_ctx;
            rec_n++;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic send(input logic [DATA_W-1:0] d, input int node, input int ctx,
                        input logic side, input bit expect_blocked);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = d;
        in_node = NODE_W'(node);
        in_ctx = CTX_W'(ctx);
        in_port = side;
        #1;
        if (expect_blocked) begin
            // R6 recirculated work holds external input back
            check(in_ready == 1'b0, "R6", longint'(in_ready), 0);
        end
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        @(negedge clk);
        #2;
        while (!done && n < 3000) begin
            @(negedge clk);
            #2;
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic fib_run(input logic [DATA_W-1:0] f0, input logic [DATA_W-1:0] f1, input int mode);
        int base;
        logic [DATA_W-1:0] a, b, c;
        bp_mode = mode;
        base = rec_n;
        send(f1, 2, 2, 1'b0, 1'b0);
        send(f0, 2, 2, 1'b1, 1'b0);
        send(f1, 2, 3, 1'b1, 1'b1);
        wait_done();
        // R9 count of host tokens
        check(rec_n - base == MAX_I - 2, "R9", longint'(rec_n - base), longint'(MAX_I - 2));
        a = f0;
        b = f1;
        for (int k = 2; k < MAX_I; k++) begin
            c = a + b;
            if (base + k - 2 < rec_n) begin
                // R9 and R4 context order and value, R3 wraparound sum
                check(rec_ctx[base + k - 2] == CTX_W'(k), "R9", longint'(rec_ctx[base + k - 2]), longint'(k));
                check(rec_data[base + k - 2] == c, "R4", longint'(rec_data[base + k - 2]), longint'(c));
            end
            a = b;
            b = c;
        end
        // R10 engine empties after the run
        check(done == 1'b1, "R10", longint'(done), 1);
        bp_mode = 0;
    endtask

    initial begin
        int base;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        check(done == 1'b1, "R1", longint'(done), 1);
        check(in_ready == 1'b1, "R1", longint'(in_ready), 1);

        // Fibonacci runs over several seeds and backpressure modes
        fib_run(32'd1, 32'd1, 0);
        fib_run(32'd0, 32'd1, 1);
        fib_run(32'd5, 32'd3, 1);
        fib_run(32'hFFFF_FFFF, 32'd2, 0);

        // R3 wraparound sum at the last context, no regeneration
        base = rec_n;
        send(32'hFFFF_FFFF, 2, MAX_I - 1, 1'b0, 1'b0);
        send(32'd2, 2, MAX_I - 1, 1'b1, 1'b0);
        wait_done();
        check(rec_n - base == 1, "R3", longint'(rec_n - base), 1);
        check(rec_data[base] == 32'd1 && rec_ctx[base] == CTX_W'(MAX_I - 1), "R3",
              longint'(rec_data[base]), 1);

        // R2 lone and same-side tokens do not fire
        base = rec_n;
        send(32'd9, 1, MAX_I - 1, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        check(rec_n == base, "R2", longint'(rec_n - base), 0);
        check(done == 1'b0, "R10", longint'(done), 0);
        send(32'd9, 1, MAX_I - 1, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        check(rec_n == base, "R2", longint'(rec_n - base), 0);
        send(32'd4, 1, MAX_I - 1, 1'b1, 1'b0);
        send(32'd5, 1, MAX_I - 1, 1'b1, 1'b0);
        wait_done();
        check(rec_n - base == 2 && rec_data[base] == 32'd13 && rec_data[base + 1] == 32'd14, "R2",
              longint'(rec_data[base]), 13);

        // R5 out-of-range contexts are swallowed
        base = rec_n;
        send(32'd7, 0, MAX_I, 1'b0, 1'b0);
        send(32'd8, 0, MAX_I, 1'b1, 1'b0);
        send(32'd8, 0, (1 << CTX_W) - 1, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        check(rec_n == base, "R5", longint'(rec_n - base), 0);
        check(done == 1'b1, "R5", longint'(done), 1);

        // R7 full store refuses unmatched tokens but accepts partners
        base = rec_n;
        for (int n = 0; n < SDEPTH; n++) send(DATA_W'(n * 10), n, MAX_I - 1, 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = 32'd77;
        in_node = '0;
        in_ctx = CTX_W'(MAX_I - 2);
        in_port = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #1;
            check(in_ready == 1'b0, "R7", longint'(in_ready), 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(rec_n == base, "R7", longint'(rec_n - base), 0);
        for (int n = 0; n < SDEPTH; n++) send(DATA_W'(n), n, MAX_I - 1, 1'b1, 1'b0);
        wait_done();
        check(rec_n - base == SDEPTH, "R7", longint'(rec_n - base), SDEPTH);
        for (int n = 0; n < SDEPTH; n++) begin
            if (base + n < rec_n)
                check(rec_data[base + n] == DATA_W'(n * 11), "R7", longint'(rec_data[base + n]), longint'(n * 11));
        end
        check(done == 1'b1, "R10", longint'(done), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule